// File: doc/BRIEF.md
# Sign-Magnitude Word Adder

This block adds or subtracts two signed words held in sign-magnitude form. Each word has a separate sign bit and a 30-bit magnitude built from five 6-bit bytes, so every magnitude from 0 to 1,073,741,823 can be written with either sign. Because the sign is separate, +0 and -0 are distinct encodings. When `op_valid` is high, the block takes both operands and an add/subtract select. One clock later it presents the signed result, a per-operation overflow bit and a three-way comparison of the two operands as they were given.

An overflow also sets a sticky flag. The flag stays set through later operations until an overflow test reads it. The test is the conditional jump on overflow or on no overflow. In either case the test reports the old flag value and clears the flag. The block would sit beside an accumulator: operand A plays the accumulator and operand B the memory word.

Top module: `smw_adder`

## Requirements
- R1: During and right after reset, `res_valid`, `res_neg`, `res_mag`, `res_ovf`, `ovf_flag` and `ovf_taken` are 0, and `cmp_code` is 2'b00.
- R2: An operation accepted at a rising edge (with `op_valid` high) shows its result after that edge. `res_valid` is high for exactly those cycles that follow an accepted operation.
- R3: When A and the effective B carry the same sign, `res_mag` is the sum of the magnitudes and `res_neg` is the common sign, unless the sum is zero (see R5).
- R4: When A and the effective B carry opposite signs, `res_mag` is the larger magnitude minus the smaller, and `res_neg` is the sign of the operand with the larger magnitude.
- R5: A result with zero magnitude takes the sign of A, so +0 and -0 both appear as results.
- R6: With `op_sub` = 1, the effective B is B with its sign bit inverted, and the operation is then an addition. With `op_sub` = 0, the effective B is B unchanged.
- R7: If the true magnitude of the result exceeds 1,073,741,823, `res_ovf` is 1 and `res_mag` holds the low 30 bits of the true magnitude. Otherwise `res_ovf` is 0.
- R8: An accepted operation that overflows sets `ovf_flag` after the same edge. Operations without overflow leave the flag as it is.
- R9: An edge with `ovf_test` high does two things. It makes `ovf_taken` equal, for the following cycle, to the flag value before that edge. It also clears the flag, unless an overflowing operation is accepted at the same edge, in which case the flag ends set. In cycles after an edge with `ovf_test` low, `ovf_taken` is 0.
- R10: `cmp_code` compares A with B as given, ignoring `op_sub`, as signed values. The codes are 2'b00 for equal, 2'b01 for A less than B and 2'b10 for A greater than B. +0 and -0 compare equal.
- R11: In cycles without an accepted operation, `res_neg`, `res_mag`, `res_ovf` and `cmp_code` hold their values whatever the operand inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Accept the operands at this edge |
| op_sub | input | 1 | 1 = subtract B from A, 0 = add |
| a_neg | input | 1 | Sign of A (1 = negative) |
| a_mag | input | 30 | Magnitude of A |
| b_neg | input | 1 | Sign of B (1 = negative) |
| b_mag | input | 30 | Magnitude of B |
| ovf_test | input | 1 | Overflow test: read and clear the sticky flag |
| res_valid | output | 1 | Result registers were loaded at the last edge |
| res_neg | output | 1 | Sign of the result |
| res_mag | output | 30 | Magnitude of the result |
| res_ovf | output | 1 | The last accepted operation overflowed |
| cmp_code | output | 2 | Comparison of A against B |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_taken | output | 1 | Flag value seen by the last overflow test |

## Verification
The checker assumes that `op_valid`, `op_sub` and `ovf_test` are driven to known levels in every cycle after reset. It also assumes that only the overflow test is allowed to clear the flag. The stimulus changes inputs only on falling clock edges and applies each operation for exactly one edge. It therefore never presents an operand whose validity is uncertain when the design samples it. The test is either raised on its own or together with an overflowing operation, and this covers the case where the flag is set and cleared at the same edge.

// File: rtl/smw_pkg.sv
package smw_pkg;

    localparam int BYTE_W = 6;
    localparam int NBYTES = 5;
    localparam int MAG_W  = BYTE_W * NBYTES;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
    } smw_word_t;

    typedef enum logic [1:0] {
        CMP_EQ = 2'b00,
        CMP_LT = 2'b01,
        CMP_GT = 2'b10
    } smw_cmp_e;

    // A word counts as negative only when it carries a non-zero magnitude.
    function automatic logic smw_is_neg(smw_word_t w);
        return w.neg && (w.mag != '0);
    endfunction

endpackage

// File: rtl/smw_byte_chain.sv
module smw_byte_chain #(
    parameter int BYTE_W = 6,
    parameter int NBYTES = 5,
    localparam int MAG_W = BYTE_W * NBYTES
) (
    input  logic [MAG_W-1:0] x,
    input  logic [MAG_W-1:0] y,
    input  logic             cin,
    output logic [MAG_W-1:0] sum,
    output logic             cout
);
    logic [NBYTES:0] carry;

    assign carry[0] = cin;

    // One byte-wide adder cell for each byte, chained by the carries.
    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        assign {carry[gi+1], sum[gi*BYTE_W +: BYTE_W]} =
            {1'b0, x[gi*BYTE_W +: BYTE_W]} +
            {1'b0, y[gi*BYTE_W +: BYTE_W]} +
            {{BYTE_W{1'b0}}, carry[gi]};
    end

    assign cout = carry[NBYTES];
endmodule

// File: rtl/smw_mag_unit.sv
module smw_mag_unit
    import smw_pkg::*;
(
    input  smw_word_t a_w,
    input  smw_word_t b_w,
    output smw_word_t r_w,
    output logic      ovf
);
    logic             same_sign;
    logic             a_ge;
    logic [MAG_W-1:0] big_mag, small_mag;
    logic [MAG_W-1:0] op_x, op_y;
    logic [MAG_W-1:0] sum_mag;
    logic             cout;

    assign same_sign = (a_w.neg == b_w.neg);
    assign a_ge      = (a_w.mag >= b_w.mag);
    assign big_mag   = a_ge ? a_w.mag : b_w.mag;
    assign small_mag = a_ge ? b_w.mag : a_w.mag;

    // Same signs: plain sum.  Opposite signs: larger plus inverted smaller plus one.
    assign op_x = same_sign ? a_w.mag : big_mag;
    assign op_y = same_sign ? b_w.mag : ~small_mag;

    smw_byte_chain #(
        .BYTE_W (BYTE_W),
        .NBYTES (NBYTES)
    ) chain_i (
        .x    (op_x),
        .y    (op_y),
        .cin  (~same_sign),
        .sum  (sum_mag),
        .cout (cout)
    );

    assign ovf = same_sign & cout;

    always_comb begin
        r_w.mag = sum_mag;
        if (sum_mag == '0)
            r_w.neg = a_w.neg;
        else if (same_sign)
            r_w.neg = a_w.neg;
        else
            r_w.neg = a_ge ? a_w.neg : b_w.neg;
    end
endmodule

// File: rtl/smw_compare.sv
module smw_compare
    import smw_pkg::*;
(
    input  smw_word_t a_w,
    input  smw_word_t b_w,
    output smw_cmp_e  cmp
);
    logic a_n, b_n;

    assign a_n = smw_is_neg(a_w);
    assign b_n = smw_is_neg(b_w);

    always_comb begin
        if (a_n != b_n)
            cmp = b_n ? CMP_GT : CMP_LT;
        else if (a_w.mag == b_w.mag)
            cmp = CMP_EQ;
        else if (a_w.mag > b_w.mag)
            cmp = a_n ? CMP_LT : CMP_GT;
        else
            cmp = a_n ? CMP_GT : CMP_LT;
    end
endmodule

// File: rtl/smw_ovf_sticky.sv
module smw_ovf_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic test_i,
    output logic flag_o,
    output logic taken_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o  <= 1'b0;
            taken_o <= 1'b0;
        end else begin
            taken_o <= test_i & flag_o;
            flag_o  <= (flag_o & ~test_i) | set_i;
        end
    end
endmodule

// File: rtl/smw_adder.sv
module smw_adder
    import smw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic             op_sub,
    input  logic             a_neg,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_neg,
    input  logic [MAG_W-1:0] b_mag,
    input  logic             ovf_test,
    output logic             res_valid,
    output logic             res_neg,
    output logic [MAG_W-1:0] res_mag,
    output logic             res_ovf,
    output logic [1:0]       cmp_code,
    output logic             ovf_flag,
    output logic             ovf_taken
);
    smw_word_t a_w, b_w, b_eff, sum_w, res_q;
    logic      sum_ovf, ovf_q, valid_q;
    smw_cmp_e  cmp_w, cmp_q;

    assign a_w   = '{neg: a_neg, mag: a_mag};
    assign b_w   = '{neg: b_neg, mag: b_mag};
    assign b_eff = '{neg: b_neg ^ op_sub, mag: b_mag};

    smw_mag_unit mag_i (
        .a_w (a_w),
        .b_w (b_eff),
        .r_w (sum_w),
        .ovf (sum_ovf)
    );

    smw_compare cmp_i (
        .a_w (a_w),
        .b_w (b_w),
        .cmp (cmp_w)
    );

    smw_ovf_sticky sticky_i (
        .clk     (clk),
        .rst     (rst),
        .set_i   (op_valid & sum_ovf),
        .test_i  (ovf_test),
        .flag_o  (ovf_flag),
        .taken_o (ovf_taken)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
            ovf_q   <= 1'b0;
            cmp_q   <= CMP_EQ;
        end else begin
            valid_q <= op_valid;
            if (op_valid) begin
                res_q <= sum_w;
                ovf_q <= sum_ovf;
                cmp_q <= cmp_w;
            end
        end
    end

    assign res_valid = valid_q;
    assign res_neg   = res_q.neg;
    assign res_mag   = res_q.mag;
    assign res_ovf   = ovf_q;
    assign cmp_code  = cmp_q;
endmodule

// File: rtl/smw_adder_chk.sv
module smw_adder_chk
    import smw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic             op_sub,
    input logic             ovf_test,
    input logic             res_valid,
    input logic             res_neg,
    input logic [MAG_W-1:0] res_mag,
    input logic             res_ovf,
    input logic [1:0]       cmp_code,
    input logic             ovf_flag,
    input logic             ovf_taken
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    assert_ovf_with_result_R7: assert property (@(posedge clk) disable iff (rst)
        res_ovf |-> res_valid || $stable(res_ovf));

    assert_flag_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> res_valid && res_ovf);

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(ovf_test));

    assert_taken_src_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_taken |-> $past(ovf_flag) && $past(ovf_test));

    assert_taken_fire_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_test && ovf_flag |=> ovf_taken);

    assert_cmp_legal_R10: assert property (@(posedge clk) disable iff (rst)
        cmp_code != 2'b11);

    assert_equal_sub_zero_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid && cmp_code == 2'b00 && $past(op_sub) |-> res_mag == '0);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> $stable(res_mag) && $stable(res_neg) && $stable(cmp_code));
endmodule

bind smw_adder smw_adder_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_sub    (op_sub),
    .ovf_test  (ovf_test),
    .res_valid (res_valid),
    .res_neg   (res_neg),
    .res_mag   (res_mag),
    .res_ovf   (res_ovf),
    .cmp_code  (cmp_code),
    .ovf_flag  (ovf_flag),
    .ovf_taken (ovf_taken)
);

// File: tb/smw_adder_tb_top.sv
`timescale 1ns/1ps
module smw_adder_tb_top;
    import smw_pkg::*;

    localparam longint MAXV = (longint'(1) << MAG_W) - 1;
    localparam longint MODV = longint'(1) << MAG_W;

    typedef struct packed {
        logic             neg;
        logic [MAG_W-1:0] mag;
        logic             ovf;
        logic [1:0]       cmp;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             op_valid = 1'b0;
    logic             op_sub = 1'b0;
    logic             a_neg = 1'b0;
    logic [MAG_W-1:0] a_mag = '0;
    logic             b_neg = 1'b0;
    logic [MAG_W-1:0] b_mag = '0;
    logic             ovf_test = 1'b0;
    logic             res_valid, res_neg, res_ovf, ovf_flag, ovf_taken;
    logic [MAG_W-1:0] res_mag;
    logic [1:0]       cmp_code;

    int   total = 0;
    int   bad = 0;
    bit   done = 0;
    exp_t exp_q[$];
    string name_q[$];

    always #2.5 clk = ~clk;

    smw_adder dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sub(op_sub),
        .a_neg(a_neg), .a_mag(a_mag), .b_neg(b_neg), .b_mag(b_mag),
        .ovf_test(ovf_test), .res_valid(res_valid), .res_neg(res_neg),
        .res_mag(res_mag), .res_ovf(res_ovf), .cmp_code(cmp_code),
        .ovf_flag(ovf_flag), .ovf_taken(ovf_taken)
    );

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Driver: compute the expected item from the arithmetic rules and queue it.
    task automatic do_op(input bit an, input longint am, input bit bn, input longint bm,
                         input bit sub, input bit tst, input string nm);
        longint va, vb, vbe, s, ab;
        exp_t   e;
        va  = an ? -am : am;
        vb  = bn ? -bm : bm;
        vbe = sub ? -vb : vb;
        s   = va + vbe;
        ab  = (s < 0) ? -s : s;
        e.mag = MAG_W'(ab % MODV);
        e.ovf = (ab > MAXV);
        e.neg = (s < 0) ? 1'b1 : (s > 0) ? 1'b0 : an;
        e.cmp = (va == vb) ? 2'b00 : (va < vb) ? 2'b01 : 2'b10;
        @(negedge clk);
        exp_q.push_back(e);
        name_q.push_back(nm);
        op_valid = 1'b1; op_sub = sub; ovf_test = tst;
        a_neg = an; a_mag = MAG_W'(am); b_neg = bn; b_mag = MAG_W'(bm);
        @(negedge clk);
        op_valid = 1'b0; ovf_test = 1'b0;
    endtask

    task automatic do_test(input bit exp_taken, input string nm);
        @(negedge clk);
        ovf_test = 1'b1;
        @(negedge clk);
        ovf_test = 1'b0;
        chk(ovf_taken == exp_taken, {nm, " taken"}, ovf_taken, exp_taken);
        chk(ovf_flag == 1'b0, {nm, " flag cleared"}, ovf_flag, 0);
    endtask

    // Monitor: pop and compare whenever a result is announced.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && res_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 result without operation", 1, 0);
                end else begin
                    exp_t  e;
                    string nm;
                    e  = exp_q.pop_front();
                    nm = name_q.pop_front();
                    chk(res_mag == e.mag, {nm, " magnitude"}, res_mag, e.mag);
                    chk(res_neg == e.neg, {nm, " sign"}, res_neg, e.neg);
                    chk(res_ovf == e.ovf, {nm, " R7 overflow bit"}, res_ovf, e.ovf);
                    chk(cmp_code == e.cmp, {nm, " R10 compare"}, cmp_code, e.cmp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [MAG_W-1:0] held_mag;
        logic             held_neg;
        logic [1:0]       held_cmp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(res_valid == 0, "R1 res_valid", res_valid, 0);
        chk(res_mag == 0 && res_neg == 0, "R1 result", res_mag, 0);
        chk(res_ovf == 0, "R1 res_ovf", res_ovf, 0);
        chk(ovf_flag == 0 && ovf_taken == 0, "R1 flag", ovf_flag, 0);
        chk(cmp_code == 2'b00, "R1 cmp_code", cmp_code, 0);

        do_op(0, 100, 0, 23, 0, 0, "R3 pos+pos");
        do_op(1, 64, 1, 4095, 0, 0, "R3 neg+neg");
        do_op(0, 9, 1, 30, 0, 0, "R4 small pos + big neg");
        do_op(1, 7, 0, 3, 0, 0, "R4 big neg + small pos");
        do_op(0, 5, 1, 5, 0, 0, "R5 +5 + -5 is +0");
        do_op(1, 5, 0, 5, 0, 0, "R5 -5 + +5 is -0");
        do_op(0, 10, 0, 3, 1, 0, "R6 10-3");
        do_op(1, 4, 1, 4, 1, 0, "R6 -4 - -4 is -0");
        do_op(0, 2, 1, 9, 1, 0, "R6 2 - -9");
        do_op(0, 0, 1, 0, 0, 0, "R10 +0 vs -0");
        do_op(1, 63, 0, 0, 0, 0, "R10 negative vs +0");
        chk(ovf_flag == 0, "R8 flag stays clear", ovf_flag, 0);

        do_op(0, MAXV, 0, 1, 0, 0, "R7 max+1");
        chk(ovf_flag == 1, "R8 flag set", ovf_flag, 1);
        do_op(0, 1, 0, 1, 0, 0, "R8 no-overflow op");
        chk(ovf_flag == 1, "R8 flag sticky", ovf_flag, 1);
        do_test(1, "R9 test with flag set");
        do_test(0, "R9 test with flag clear");

        do_op(1, MAXV, 0, 5, 1, 0, "R7 -max - 5");
        chk(ovf_flag == 1, "R8 flag set again", ovf_flag, 1);
        do_op(0, MAXV, 1, MAXV, 1, 1, "R9 test with overflow same edge");
        chk(ovf_taken == 1, "R9 taken old flag", ovf_taken, 1);
        chk(ovf_flag == 1, "R9 set wins over clear", ovf_flag, 1);
        do_test(1, "R9 final test");

        // R11: outputs hold with no accepted operation
        do_op(0, 12345, 1, 678, 0, 0, "R11 setup");
        held_mag = res_mag; held_neg = res_neg; held_cmp = cmp_code;
        a_mag = 30'h1; b_mag = 30'h3FFF_FFFF; b_neg = 1'b0; op_sub = 1'b1;
        repeat (3) @(negedge clk);
        chk(res_valid == 0, "R2 res_valid low when idle", res_valid, 0);
        chk(res_mag == held_mag, "R11 magnitude held", res_mag, held_mag);
        chk(res_neg == held_neg, "R11 sign held", res_neg, held_neg);
        chk(cmp_code == held_cmp, "R11 compare held", cmp_code, held_cmp);
        chk(exp_q.size() == 0, "R2 every operation produced a result", exp_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule